// File: doc/BRIEF.md
# Serial-to-Parallel Output Expander Controller

This block drives a chain of external serial-in/parallel-out shift registers from a 32-bit register interface. The chain holds up to three 8-bit groups, so up to 24 output pins. The block sends each output frame MSB first on a serial data line with a shift clock. After the last bit it pulses a latch strobe so that the external registers show the new pattern all at once.

The CPU data register supplies each frame bit by default. Up to fourteen of the lowest frame bits can be taken from hardware status inputs instead, each bit under its own enable. Bits 0-1 come from a 2-bit modem status input. Bits 2-13 come from four 3-bit PHY status inputs. A frame goes out once when software writes the self-clearing update bit. It goes out on a fixed period when hardware-driven bits are enabled and the update timer has a clock source selected.

A single state machine drives the serial side. Its states are IDLE, LOAD, SETUP, ACTIVE and LATCH. Its transitions are:
- IDLE→LOAD when a software or timer trigger is pending.
- LOAD→IDLE when no group is enabled.
- LOAD→SETUP when at least one group is enabled.
- SETUP→ACTIVE after one cycle.
- ACTIVE→SETUP while bits remain.
- ACTIVE→LATCH after the last bit.
- LATCH→IDLE after the one-cycle strobe.

Top module: `sipo_expander_ctrl`

## Requirements
- R1: The registers sit at these byte offsets: control-A at 0x00, control-B at 0x04, data-A at 0x08, data-B at 0x0C and access at 0x10. Data-A, data-B and access read back the last value written. Control-B reads back all 32 bits. Control-A reads back bits 30:0, and bit 31 reads as the update-busy flag.
- R2: After reset all registers read 0, and ser_data, shift_clk and latch_strobe are 0.
- R3: Control-B bits [2:0] enable groups 0..2. The frame length is 8×(index of the highest enabled group + 1). With no group enabled, a trigger sends nothing and the busy flag clears.
- R4: Each bit takes two cycles: a setup cycle with the clock idle, then a cycle with the clock active. Data is held over both cycles. Bits go out MSB first. latch_strobe is high for exactly one cycle after the last bit.
- R5: Control-A bit 26 = 1 gives an idle-high clock, so data is taken on the falling edge. Bit 26 = 0 gives an idle-low clock, so data is taken on the rising edge.
- R6: Writing control-A with bit 31 = 1 starts a frame when no hardware enable is set. Control-A bit 31 then reads 1 until the frame's strobe, and 0 afterwards.
- R7: A software update write is ignored while any hardware enable is nonzero: bit 31 stays 0 and no frame goes out.
- R8: A software trigger that arrives while a frame is being shifted is held. One more frame follows the current one, and then the busy flag clears.
- R9: Control-A bits [25:24]: when bit 24+i is set, frame bit i is taken from modem_stat[i] instead of data-A bit i.
- R10: Each PHY n has a 3-bit enable. When enable bit j is set, frame bit base+j is taken from phyn_stat[j]. The enables and bases are:
  - PHY1: enable in control-A [29:27], base 2.
  - PHY2: enable in control-B [5:3], base 5.
  - PHY3: enable in control-B [8:6], base 8.
  - PHY4: enable in control-B [17:15], base 11.
- R11: When any hardware enable is set and control-B [31:30] is nonzero, a frame is started every P×TICK_DIV cycles. Control-B [24:23] selects P: 00 gives 20, 01 gives 10, 10 gives 5 and 11 gives 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| modem_stat | input | 2 | Modem status bits |
| phy1_stat | input | 3 | PHY1 status bits |
| phy2_stat | input | 3 | PHY2 status bits |
| phy3_stat | input | 3 | PHY3 status bits |
| phy4_stat | input | 3 | PHY4 status bits |
| ser_data | output | 1 | Serial data to the chain |
| shift_clk | output | 1 | Shift clock to the chain |
| latch_strobe | output | 1 | One-cycle parallel latch pulse |

## Verification
Some behaviour is checked by assertions on every cycle:
- the strobe lasts one cycle;
- data holds across each active clock phase;
- the clock sits at its idle level during the strobe;
- the bit counter stays inside the frame length;
- an empty frame returns straight to IDLE.

Other behaviour needs the bench's scenarios. A model of the external chain compares the latched pattern against the expected merge of data and status bits for each edge mode and group setting. Timer periods are measured between strobes. The busy flag's self-clear, the held trigger and the ignored software write are also checked by scenario.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int GROUP_W    = 8;
    localparam int NUM_GROUPS = 3;
    localparam int FRAME_W    = GROUP_W * NUM_GROUPS;
    localparam int HW_BITS    = 14;

    localparam logic [4:0] OFS_CTL_A  = 5'h00;
    localparam logic [4:0] OFS_CTL_B  = 5'h04;
    localparam logic [4:0] OFS_DATA_A = 5'h08;
    localparam logic [4:0] OFS_DATA_B = 5'h0C;
    localparam logic [4:0] OFS_ACCESS = 5'h10;

    // control-A field positions
    localparam int CA_UPDATE  = 31;
    localparam int CA_PHY1_LO = 27;
    localparam int CA_EDGE    = 26;
    localparam int CA_MODEM_LO = 24;
    // control-B field positions
    localparam int CB_SRC_LO  = 30;
    localparam int CB_RATE_LO = 23;
    localparam int CB_PHY4_LO = 15;
    localparam int CB_PHY3_LO = 6;
    localparam int CB_PHY2_LO = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETUP,
        ST_ACTIVE,
        ST_LATCH
    } shift_state_e;

    // timer units per update for each rate code
    function automatic logic [4:0] rate_units(input logic [1:0] code);
        logic [4:0] u;
        unique case (code)
            2'b00: u = 5'd20;
            2'b01: u = 5'd10;
            2'b10: u = 5'd5;
            default: u = 5'd4;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/sipo_regs.sv
module sipo_regs
    import sipo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    input  logic        sw_busy,
    output logic [31:0] reg_rdata,
    output logic [31:0] ctl_a,
    output logic [31:0] ctl_b,
    output logic [31:0] data_a,
    output logic        sw_set
);

    logic [31:0] ctl_a_q, ctl_b_q, data_a_q, data_b_q, access_q;
    logic        wr_ctl_a;
    logic        hw_in_b;
    logic        hw_in_wdata;

    assign wr_ctl_a = reg_wr && (reg_addr == OFS_CTL_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_a_q  <= '0;
            ctl_b_q  <= '0;
            data_a_q <= '0;
            data_b_q <= '0;
            access_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                OFS_CTL_A:  ctl_a_q  <= {1'b0, reg_wdata[30:0]};
                OFS_CTL_B:  ctl_b_q  <= reg_wdata;
                OFS_DATA_A: data_a_q <= reg_wdata;
                OFS_DATA_B: data_b_q <= reg_wdata;
                OFS_ACCESS: access_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // a software update is honoured only with every hardware enable clear
    assign hw_in_b     = |{ctl_b_q[CB_PHY4_LO +: 3], ctl_b_q[CB_PHY3_LO +: 3],
                           ctl_b_q[CB_PHY2_LO +: 3]};
    assign hw_in_wdata = |{reg_wdata[CA_PHY1_LO +: 3], reg_wdata[CA_MODEM_LO +: 2]};
    assign sw_set      = wr_ctl_a && reg_wdata[CA_UPDATE] && !hw_in_wdata && !hw_in_b;

    always_comb begin
        unique case (reg_addr)
            OFS_CTL_A:  reg_rdata = {sw_busy, ctl_a_q[30:0]};
            OFS_CTL_B:  reg_rdata = ctl_b_q;
            OFS_DATA_A: reg_rdata = data_a_q;
            OFS_DATA_B: reg_rdata = data_b_q;
            OFS_ACCESS: reg_rdata = access_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign ctl_a  = ctl_a_q;
    assign ctl_b  = ctl_b_q;
    assign data_a = data_a_q;

endmodule

// File: rtl/sipo_merge.sv
module sipo_merge
    import sipo_pkg::*;
(
    input  logic [FRAME_W-1:0] cpu_bits,
    input  logic [1:0]         modem_en,
    input  logic [2:0]         phy1_en,
    input  logic [2:0]         phy2_en,
    input  logic [2:0]         phy3_en,
    input  logic [2:0]         phy4_en,
    input  logic [1:0]         modem_stat,
    input  logic [2:0]         phy1_stat,
    input  logic [2:0]         phy2_stat,
    input  logic [2:0]         phy3_stat,
    input  logic [2:0]         phy4_stat,
    output logic [FRAME_W-1:0] frame,
    output logic               hw_any
);

    logic [HW_BITS-1:0] hw_en;
    logic [HW_BITS-1:0] hw_val;

    assign hw_en  = {phy4_en, phy3_en, phy2_en, phy1_en, modem_en};
    assign hw_val = {phy4_stat, phy3_stat, phy2_stat, phy1_stat, modem_stat};
    assign hw_any = |hw_en;

    for (genvar i = 0; i < FRAME_W; i++) begin : g_bit
        if (i < HW_BITS) begin : g_hw
            assign frame[i] = hw_en[i] ? hw_val[i] : cpu_bits[i];
        end else begin : g_cpu
            assign frame[i] = cpu_bits[i];
        end
    end

endmodule

// File: rtl/sipo_timer.sv
module sipo_timer
    import sipo_pkg::*;
#(
    parameter int TICK_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int DIV_W = $clog2(TICK_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] unit_cnt;
    logic [4:0]       per_cnt;
    logic [4:0]       per_last;
    logic             unit_end;

    assign per_last = rate_units(rate) - 5'd1;
    assign unit_end = (unit_cnt == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_cnt <= '0;
            per_cnt  <= '0;
        end else if (!run) begin
            unit_cnt <= '0;
            per_cnt  <= '0;
        end else if (unit_end) begin
            unit_cnt <= '0;
            per_cnt  <= (per_cnt >= per_last) ? 5'd0 : per_cnt + 5'd1;
        end else begin
            unit_cnt <= unit_cnt + 1'b1;
        end
    end

    assign tick = run && unit_end && (per_cnt >= per_last);

endmodule

// File: rtl/sipo_shifter.sv
module sipo_shifter
    import sipo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [NUM_GROUPS-1:0] group_en,
    input  logic               edge_fall,
    input  logic               sw_set,
    input  logic               tick,
    output logic               ser_data,
    output logic               shift_clk,
    output logic               latch_strobe,
    output logic               sw_busy
);

    localparam int LEN_W = $clog2(FRAME_W + 1);

    shift_state_e state, state_nx;

    logic [FRAME_W-1:0] frame_q;
    logic [LEN_W-1:0]   len_now, len_q, bit_cnt;
    logic               sw_req, sw_again, svc_sw, tmr_pend;
    logic               finish;

    always_comb begin
        len_now = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (group_en[g]) len_now = LEN_W'((g + 1) * GROUP_W);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sw_req || tmr_pend) state_nx = ST_LOAD;
            ST_LOAD:   state_nx = (len_now == '0) ? ST_IDLE : ST_SETUP;
            ST_SETUP:  state_nx = ST_ACTIVE;
            ST_ACTIVE: state_nx = (bit_cnt == '0) ? ST_LATCH : ST_SETUP;
            ST_LATCH:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign finish = (state == ST_LATCH) || (state == ST_LOAD && len_now == '0);

    // datapath and trigger bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= '0;
            len_q    <= '0;
            bit_cnt  <= '0;
            sw_req   <= 1'b0;
            sw_again <= 1'b0;
            svc_sw   <= 1'b0;
            tmr_pend <= 1'b0;
        end else begin
            if (tick)
                tmr_pend <= 1'b1;
            else if (state == ST_LOAD)
                tmr_pend <= 1'b0;

            if (state == ST_LOAD) begin
                svc_sw  <= sw_req;
                len_q   <= len_now;
                bit_cnt <= len_now - 1'b1;
                frame_q <= frame_in << (FRAME_W - int'(len_now));
            end else if (state == ST_ACTIVE) begin
                bit_cnt <= bit_cnt - 1'b1;
                frame_q <= frame_q << 1;
            end

            if (sw_set && state != ST_IDLE)
                sw_again <= 1'b1;
            else if (state == ST_LOAD)
                sw_again <= 1'b0;

            if (sw_set)
                sw_req <= 1'b1;
            else if (finish && (svc_sw || state == ST_LOAD) && !sw_again)
                sw_req <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ser_data     = 1'b0;
        shift_clk    = edge_fall;
        latch_strobe = 1'b0;
        unique case (state)
            ST_SETUP:  ser_data = frame_q[FRAME_W-1];
            ST_ACTIVE: begin
                ser_data  = frame_q[FRAME_W-1];
                shift_clk = ~edge_fall;
            end
            ST_LATCH:  latch_strobe = 1'b1;
            default: ;
        endcase
    end

    assign sw_busy = sw_req;

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |=> !latch_strobe);

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |-> $stable(ser_data));

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |-> (shift_clk == edge_fall));

    assert_empty_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && len_now == '0) |=> (state == ST_IDLE));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP || state == ST_ACTIVE) |-> (bit_cnt < len_q));

endmodule

// File: rtl/sipo_expander_ctrl.sv
module sipo_expander_ctrl
    import sipo_pkg::*;
#(
    parameter int TICK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  modem_stat,
    input  logic [2:0]  phy1_stat,
    input  logic [2:0]  phy2_stat,
    input  logic [2:0]  phy3_stat,
    input  logic [2:0]  phy4_stat,
    output logic        ser_data,
    output logic        shift_clk,
    output logic        latch_strobe
);

    logic [31:0]        ctl_a, ctl_b, data_a;
    logic               sw_set, sw_busy, hw_any, tick, tmr_run;
    logic [FRAME_W-1:0] frame;

    sipo_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .sw_busy   (sw_busy),
        .reg_rdata (reg_rdata),
        .ctl_a     (ctl_a),
        .ctl_b     (ctl_b),
        .data_a    (data_a),
        .sw_set    (sw_set)
    );

    sipo_merge u_merge (
        .cpu_bits   (data_a[FRAME_W-1:0]),
        .modem_en   (ctl_a[CA_MODEM_LO +: 2]),
        .phy1_en    (ctl_a[CA_PHY1_LO +: 3]),
        .phy2_en    (ctl_b[CB_PHY2_LO +: 3]),
        .phy3_en    (ctl_b[CB_PHY3_LO +: 3]),
        .phy4_en    (ctl_b[CB_PHY4_LO +: 3]),
        .modem_stat (modem_stat),
        .phy1_stat  (phy1_stat),
        .phy2_stat  (phy2_stat),
        .phy3_stat  (phy3_stat),
        .phy4_stat  (phy4_stat),
        .frame      (frame),
        .hw_any     (hw_any)
    );

    assign tmr_run = hw_any && (ctl_b[CB_SRC_LO +: 2] != 2'b00);

    sipo_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .rate  (ctl_b[CB_RATE_LO +: 2]),
        .tick  (tick)
    );

    sipo_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_in     (frame),
        .group_en     (ctl_b[NUM_GROUPS-1:0]),
        .edge_fall    (ctl_a[CA_EDGE]),
        .sw_set       (sw_set),
        .tick         (tick),
        .ser_data     (ser_data),
        .shift_clk    (shift_clk),
        .latch_strobe (latch_strobe),
        .sw_busy      (sw_busy)
    );

endmodule

// File: tb/tb_sipo_expander_ctrl.sv
module tb_sipo_expander_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 8;

    typedef struct packed {
        logic [31:0] c_a;
        logic [31:0] c_b;
        logic [31:0] d_a;
        logic [1:0]  md;
        logic [2:0]  p1, p2, p3, p4;
        logic        sw;
        logic [23:0] exp_bits;
        logic [15:0] exp_gap;
    } vec_t;

    // R9/R10 expected merges worked out from the field rules
    localparam vec_t VECS [5] = '{
        '{32'h04000000, 32'h00000001, 32'h000000A5, 2'b00, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 24'h0000A5, 16'd0},
        '{32'h00000000, 32'h00000003, 32'h00123456, 2'b00, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 24'h003456, 16'd0},
        '{32'h04000000, 32'h00000004, 32'h00ABCDEF, 2'b00, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 24'hABCDEF, 16'd0},
        '{32'h2B000000, 32'h41800001, 32'h000000FF, 2'b01, 3'b010, 3'd0, 3'd0, 3'd0, 1'b0, 24'h0000E9, 16'd32},
        '{32'h00000000, 32'h400080FB, 32'h00000000, 2'b00, 3'd0, 3'b101, 3'b111, 3'b001, 1'b0, 24'h000BA0, 16'd160}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  modem_stat = '0;
    logic [2:0]  phy1_stat = '0, phy2_stat = '0, phy3_stat = '0, phy4_stat = '0;
    logic        ser_data, shift_clk, latch_strobe;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nstrobe = 0;
    int last_strobe = 0;
    int gap = 0;
    logic        edge_fall_m = 1'b0;
    logic        prev_sclk = 1'b0;
    logic [23:0] chain = '0;
    logic [23:0] par = '0;

    sipo_expander_ctrl #(.TICK_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .modem_stat(modem_stat),
        .phy1_stat(phy1_stat), .phy2_stat(phy2_stat), .phy3_stat(phy3_stat),
        .phy4_stat(phy4_stat), .ser_data(ser_data), .shift_clk(shift_clk),
        .latch_strobe(latch_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // model of the external register chain
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (edge_fall_m ? (prev_sclk && !shift_clk) : (!prev_sclk && shift_clk))
            chain <= {chain[22:0], ser_data};
        prev_sclk <= shift_clk;
        if (latch_strobe) begin
            par <= chain;
            nstrobe <= nstrobe + 1;
            gap <= cyc - last_strobe;
            last_strobe <= cyc;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step();
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        step();
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_strobes(input int n, input string req);
        int start = nstrobe;
        int k = 0;
        while (nstrobe < start + n && k < 3000) begin
            step();
            k++;
        end
        step();
        check(nstrobe >= start + n, req, nstrobe - start, n);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic logic [23:0] len_mask(input logic [2:0] g);
        if (g[2]) return 24'hFFFFFF;
        if (g[1]) return 24'h00FFFF;
        if (g[0]) return 24'h0000FF;
        return 24'h0;
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int s0;

        // R2: reset state
        idle(3);
        check(ser_data == 1'b0 && shift_clk == 1'b0 && latch_strobe == 1'b0, "R2 outputs in reset",
              {ser_data, shift_clk, latch_strobe}, 0);
        rst_n = 1'b1;
        for (int a = 0; a <= 16; a += 4) begin
            rd(5'(a), r);
            check(r == 32'h0, "R2 register reset", r, 0);
        end

        // R1: readback
        wr(5'h08, 32'hDEADBEEF); rd(5'h08, r); check(r == 32'hDEADBEEF, "R1 data-A", r, 32'hDEADBEEF);
        wr(5'h0C, 32'h13572468); rd(5'h0C, r); check(r == 32'h13572468, "R1 data-B", r, 32'h13572468);
        wr(5'h10, 32'h0F0F00FF); rd(5'h10, r); check(r == 32'h0F0F00FF, "R1 access", r, 32'h0F0F00FF);
        wr(5'h04, 32'h00300000); rd(5'h04, r); check(r == 32'h00300000, "R1 control-B", r, 32'h00300000);
        wr(5'h04, 32'h0);

        // vector table: R3 R4 R5 R9 R10 R11
        foreach (VECS[i]) begin
            edge_fall_m = VECS[i].c_a[26];
            wr(5'h00, VECS[i].c_a);
            wr(5'h08, VECS[i].d_a);
            modem_stat = VECS[i].md;
            phy1_stat = VECS[i].p1; phy2_stat = VECS[i].p2;
            phy3_stat = VECS[i].p3; phy4_stat = VECS[i].p4;
            wr(5'h04, VECS[i].c_b);
            if (VECS[i].sw) begin
                wr(5'h00, VECS[i].c_a | 32'h80000000);
                wait_strobes(1, "R4 strobe per software frame");
            end else begin
                wait_strobes(2, "R11 timer frames");
                check(gap == int'(VECS[i].exp_gap), "R11 update period", gap, VECS[i].exp_gap);
                if (i == 3) begin
                    // R11: rate code 10 gives 5 units
                    wr(5'h04, 32'h41000001);
                    wait_strobes(3, "R11 timer frames");
                    check(gap == 5 * TDIV, "R11 update period rate 10", gap, 5 * TDIV);
                    wr(5'h04, VECS[i].c_b);
                    wait_strobes(2, "R11 timer frames");
                end
            end
            check((par & len_mask(VECS[i].c_b[2:0])) == VECS[i].exp_bits,
                  "R3 R4 R5 R9 R10 latched frame", par & len_mask(VECS[i].c_b[2:0]), VECS[i].exp_bits);
            wr(5'h04, 32'h0);
            idle(80);
        end

        // R6: busy flag self-clears after the strobe
        edge_fall_m = 1'b0;
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h0000003C);
        wr(5'h04, 32'h00000001);
        wr(5'h00, 32'h80000000);
        rd(5'h00, r);
        check(r[31] == 1'b1, "R6 busy while shifting", r[31], 1);
        wait_strobes(1, "R6 software frame");
        rd(5'h00, r);
        check(r[31] == 1'b0, "R6 busy cleared", r[31], 0);
        check(par[7:0] == 8'h3C, "R6 frame content", par[7:0], 8'h3C);

        // R8: trigger during a frame is held
        s0 = nstrobe;
        wr(5'h00, 32'h80000000);
        idle(4);
        wr(5'h00, 32'h80000000);
        idle(100);
        check(nstrobe - s0 == 2, "R8 held trigger frames", nstrobe - s0, 2);
        rd(5'h00, r);
        check(r[31] == 1'b0, "R8 busy cleared", r[31], 0);

        // R3: no group enabled
        wr(5'h04, 32'h0);
        s0 = nstrobe;
        wr(5'h00, 32'h80000000);
        idle(20);
        check(nstrobe == s0, "R3 no frame without groups", nstrobe - s0, 0);
        rd(5'h00, r);
        check(r[31] == 1'b0, "R3 busy cleared without groups", r[31], 0);

        // R7: software write ignored with a hardware enable, timer source off
        wr(5'h04, 32'h00000009);
        s0 = nstrobe;
        wr(5'h00, 32'h80000000);
        rd(5'h00, r);
        check(r[31] == 1'b0, "R7 update bit ignored", r[31], 0);
        idle(60);
        check(nstrobe == s0, "R7 no frame", nstrobe - s0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule